// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns a fast system clock into the bit timing of a node on a CAN-style wired-AND serial bus. A prescaler divides the system clock into time quanta. The nominal bit is a run-time number of quanta. Within each bit the block raises a sample strobe at a chosen quantum and latches the bus level there. It raises a boundary strobe on the last quantum, which a transmitter uses to present its next bit.

The received line first passes through a two-flop synchronizer. Only transitions from the recessive level to the dominant level are used for synchronization. While the bus is idle, such a transition restarts both the quantum counter and the prescaler, so the frame start becomes quantum zero of a fresh bit.

During a frame, an edge that lands after quantum zero but no later than the sample quantum arrives late, and the running bit gains one quantum. An edge that lands after the sample quantum arrives early, and the running bit loses one quantum. Only one such correction is made per bit. Frame decoding, stuffing, CRC and error handling belong to other blocks.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_stb` is high for one system clock in every `cfg_brp` clocks, counted from reset or from the last hard synchronization. `cfg_brp` must be at least 1.
- R2: When no edge intervenes, a bit lasts `cfg_nbq` quanta (9 to 20). `bit_stb` rises together with `tq_stb` on the quantum whose index is the bit's last. Indices count from 0.
- R3: `sample_stb` rises together with `tq_stb` at the end of quantum `cfg_samp`. At that point `rx_bit` takes the synchronized bus level, with dominant read as 0 and recessive as 1. The range is 1 <= `cfg_samp` <= `cfg_nbq`-2, about two thirds into the bit.
- R4: A falling edge seen during a frame while the quantum index is between 1 and `cfg_samp` lengthens the current bit to `cfg_nbq`+1 quanta.
- R5: A falling edge seen during a frame while the quantum index is above `cfg_samp` shortens the current bit to `cfg_nbq`-1 quanta.
- R6: A falling edge at quantum index 0 changes nothing. At most one lengthening or shortening is applied per bit, and later edges in that bit are ignored.
- R7: `bus_idle` is 1 after reset, and it is 1 after 11 consecutive samples read recessive. A dominant sample clears the count.
- R8: A falling edge while `bus_idle` is 1 is a hard synchronization. In that cycle `sample_stb` and `bit_stb` stay low. From the next cycle the quantum index and the prescaler restart at 0, and `bus_idle` drops.
- R9: Rising (dominant-to-recessive) transitions never adjust timing.
- R10: A change on `rx_in` before clock edge k is acted on as an edge in the cycle that follows clock edge k+1. This is the two-flop synchronizer delay.
- R11: `cfg_brp`, `cfg_nbq` and `cfg_samp` are inputs, taken as set while in reset. All of the above holds for each setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_brp | input | 8 | Prescaler divisor, system clocks per quantum |
| cfg_nbq | input | 5 | Nominal quanta per bit |
| cfg_samp | input | 5 | Quantum index of the sample point |
| rx_in | input | 1 | Asynchronous received bus level, 0 dominant |
| tq_stb | output | 1 | Quantum tick |
| sample_stb | output | 1 | Sample point strobe |
| rx_bit | output | 1 | Bus level latched at the last sample point |
| bit_stb | output | 1 | Last quantum of the current bit |
| bus_idle | output | 1 | Bus seen idle (11 recessive samples) |

## Verification
A synchronization edge can land in the same system clock as a quantum tick. When that tick is the sample tick, a late edge decides the bit length on the very quantum being sampled. When the bus is idle, the edge is a hard synchronization and must suppress the sample and boundary strobes of that tick. The bench provokes these collisions in three ways. It drives senders that run slower or faster than nominal. It drives narrow dominant pulses at many offsets inside a bit. It lets the bus fall idle and then starts a frame. It runs all of this at three prescaler and bit-length settings, and judges every output on every clock against a behavioural reference model.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
    localparam int BRP_W = 8;   // prescaler divisor width
    localparam int QW    = 5;   // quantum index / bit length width

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'b00,
        ADJ_LONG  = 2'b01,
        ADJ_SHORT = 2'b10
    } adj_e;
endpackage

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);
    typedef struct packed {
        logic m1;
        logic m2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.m1   = rx_in;
        st_d.m2   = st_q.m1;
        st_d.prev = st_q.m2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{m1: 1'b1, m2: 1'b1, prev: 1'b1};
        else        st_q <= st_d;
    end

    assign rx_s = st_q.m2;
    assign fall = st_q.prev & ~st_q.m2;
endmodule

// File: rtl/cbt_tq_prescaler.sv
module cbt_tq_prescaler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp,
    input  logic             clr,
    output logic             tick
);
    logic [BRP_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q >= brp - BRP_W'(1));

    always_comb begin
        cnt_d = cnt_q + BRP_W'(1);
        if (clr || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/cbt_bit_seq.sv
module cbt_bit_seq
    import can_bt_pkg::*;
#(
    parameter int IDLE_BITS = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          fall,
    input  logic          rx_s,
    input  logic [QW-1:0] nbq,
    input  logic [QW-1:0] samp,
    output logic          sample_stb,
    output logic          bit_stb,
    output logic          hard_sync,
    output logic          rx_bit,
    output logic          bus_idle
);
    localparam int IW = $clog2(IDLE_BITS + 1);

    typedef struct packed {
        logic [QW-1:0] idx;
        adj_e          adj;
        logic [IW-1:0] idle_cnt;
        logic          rx_bit;
    } seq_t;

    seq_t st_d, st_q;

    logic          idle, open_win, late, early, last_q;
    logic [QW:0]   nbq_x, eff_len;

    always_comb begin
        st_d     = st_q;
        idle     = (st_q.idle_cnt >= IW'(IDLE_BITS));
        hard_sync = fall && idle;
        open_win = fall && !idle && (st_q.adj == ADJ_NONE);
        late     = open_win && (st_q.idx != '0) && (st_q.idx <= samp);
        early    = open_win && (st_q.idx > samp);

        nbq_x = {1'b0, nbq};
        if (late || st_q.adj == ADJ_LONG)        eff_len = nbq_x + (QW+1)'(1);
        else if (early || st_q.adj == ADJ_SHORT) eff_len = nbq_x - (QW+1)'(1);
        else                                     eff_len = nbq_x;

        last_q     = (({1'b0, st_q.idx} + (QW+1)'(1)) >= eff_len);
        sample_stb = tick && (st_q.idx == samp) && !hard_sync;
        bit_stb    = tick && last_q && !hard_sync;

        if (hard_sync) begin
            st_d.idx      = '0;
            st_d.adj      = ADJ_NONE;
            st_d.idle_cnt = '0;
        end else begin
            if (late)  st_d.adj = ADJ_LONG;
            if (early) st_d.adj = ADJ_SHORT;
            if (bit_stb) begin
                st_d.idx = '0;
                st_d.adj = ADJ_NONE;
            end else if (tick) begin
                st_d.idx = st_q.idx + QW'(1);
            end
        end

        if (sample_stb) begin
            st_d.rx_bit = rx_s;
            if (!rx_s)                              st_d.idle_cnt = '0;
            else if (st_q.idle_cnt < IW'(IDLE_BITS)) st_d.idle_cnt = st_q.idle_cnt + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx      <= '0;
            st_q.adj      <= ADJ_NONE;
            st_q.idle_cnt <= IW'(IDLE_BITS);
            st_q.rx_bit   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_bit   = st_q.rx_bit;
    assign bus_idle = idle;

    // R3
    samp_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> tick);
    // R2
    bit_end_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> (tick && !sample_stb));
    // R6
    one_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.adj != ADJ_NONE && !bit_stb && !hard_sync) |=> (st_q.adj == $past(st_q.adj)));
    // R8
    hard_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_sync |=> (st_q.idx == '0 && st_q.adj == ADJ_NONE && !bus_idle));
    // R7
    idle_from_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_idle) |-> ($past(sample_stb) && $past(rx_s)));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [QW-1:0]    cfg_nbq,
    input  logic [QW-1:0]    cfg_samp,
    input  logic             rx_in,
    output logic             tq_stb,
    output logic             sample_stb,
    output logic             rx_bit,
    output logic             bit_stb,
    output logic             bus_idle
);
    logic rx_s, fall, hard_sync;

    cbt_rx_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_in (rx_in),
        .rx_s  (rx_s),
        .fall  (fall)
    );

    cbt_tq_prescaler u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .brp   (cfg_brp),
        .clr   (hard_sync),
        .tick  (tq_stb)
    );

    cbt_bit_seq #(.IDLE_BITS(11)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tq_stb),
        .fall       (fall),
        .rx_s       (rx_s),
        .nbq        (cfg_nbq),
        .samp       (cfg_samp),
        .sample_stb (sample_stb),
        .bit_stb    (bit_stb),
        .hard_sync  (hard_sync),
        .rx_bit     (rx_bit),
        .bus_idle   (bus_idle)
    );
endmodule

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_brp = 8'd2;
    logic [4:0] cfg_nbq = 5'd10;
    logic [4:0] cfg_samp = 5'd6;
    logic       rx_in = 1'b1;
    logic       tq_stb, sample_stb, rx_bit, bit_stb, bus_idle;

    always #2.5 clk = ~clk;

    can_bit_timer u_can_bit_timer (
        .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_nbq(cfg_nbq),
        .cfg_samp(cfg_samp), .rx_in(rx_in), .tq_stb(tq_stb),
        .sample_stb(sample_stb), .rx_bit(rx_bit), .bit_stb(bit_stb),
        .bus_idle(bus_idle)
    );

    int vectors = 0, fails = 0, cycles = 0;
    bit done = 0;
    string cur = "R7 reset";

    // reference model state
    int m1, m2, mp, pc, idx, dl, ic, rb;
    int e_tick, e_edge, e_idle, e_hard, e_late, e_early, e_len, e_samp, e_bit;

    task automatic model_reset();
        m1 = 1; m2 = 1; mp = 1; pc = 0; idx = 0; dl = 0; ic = 11; rb = 1;
    endtask

    task automatic eval();
        int b, n, s;
        b = cfg_brp; n = cfg_nbq; s = cfg_samp;
        e_tick  = (pc >= b - 1);
        e_edge  = (mp == 1 && m2 == 0);
        e_idle  = (ic >= 11);
        e_hard  = e_edge && e_idle;
        e_late  = e_edge && !e_idle && dl == 0 && idx != 0 && idx <= s;
        e_early = e_edge && !e_idle && dl == 0 && idx > s;
        e_len   = n + (e_late ? 1 : (e_early ? -1 : dl));
        e_samp  = e_tick && idx == s && !e_hard;
        e_bit   = e_tick && (idx >= e_len - 1) && !e_hard;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            eval();
            if (e_hard) begin
                pc = 0; idx = 0; dl = 0; ic = 0;
            end else begin
                pc = e_tick ? 0 : pc + 1;
                if (e_late)  dl = 1;
                if (e_early) dl = -1;
                if (e_bit) begin idx = 0; dl = 0; end
                else if (e_tick) idx = idx + 1;
            end
            if (e_samp) begin
                rb = m2;
                ic = (m2 == 0) ? 0 : (ic < 11 ? ic + 1 : 11);
            end
            mp = m2; m2 = m1; m1 = rx_in;
        end
    end

    task automatic cmp(string req, int got, int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s [%s] got %0d expected %0d at cycle %0d", req, cur, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            if (!rst_n) model_reset();
            eval();
            cmp("R1 tq_stb",     tq_stb,     e_tick);
            cmp("R2 bit_stb",    bit_stb,    e_bit);
            cmp("R3 sample_stb", sample_stb, e_samp);
            cmp("R3 rx_bit",     rx_bit,     rb);
            cmp("R7 bus_idle",   bus_idle,   e_idle);
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog expired, got %0d cycles expected under 150000", cycles);
                done = 1;
                $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(string bits, int cyc);
        for (int i = 0; i < bits.len(); i++) begin
            rx_in = (bits[i] == "1");
            wait_cyc(cyc);
        end
    endtask

    task automatic glitches(int nb);
        // narrow dominant pulses at drifting offsets: several falling edges per bit
        for (int i = 0; i < nb; i++) begin
            rx_in = 1'b0; wait_cyc(1 + (i % 3));
            rx_in = 1'b1; wait_cyc(2 + (i % 5));
        end
    endtask

    task automatic suite(int b, int n, int s);
        int bc;
        bc = b * n;
        rst_n = 1'b0; rx_in = 1'b1;
        cfg_brp = 8'(b); cfg_nbq = 5'(n); cfg_samp = 5'(s);
        cur = $sformatf("R11 reset at brp=%0d nbq=%0d samp=%0d", b, n, s);
        wait_cyc(4);
        rst_n = 1'b1;
        cur = "R1 R2 R3 R7 idle recessive run";
        wait_cyc(3 * bc + 7);
        cur = "R8 R10 hard sync on frame start";
        send("0", bc);
        cur = "R4 R9 slow sender, late edges";
        send("010011010110", bc + b);
        cur = "R5 R9 fast sender, early edges";
        send("010110010101", bc - b);
        cur = "R6 edge on tick and repeated edges in one bit";
        glitches(4 * n);
        send("0101", bc + 1);
        cur = "R7 return to idle after 11 recessive samples";
        rx_in = 1'b1;
        wait_cyc(13 * bc);
        cur = "R8 second hard sync after idle";
        send("00101", bc);
        rx_in = 1'b1;
        wait_cyc(12 * bc);
    endtask

    initial begin
        suite(2, 10, 6);
        suite(1, 20, 13);
        suite(3, 9, 5);
        @(negedge clk);
        #1;
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule